// File: doc/BRIEF.md
# Indirect Register Window for a Network Controller

This block is the slave-side register front end of a network controller. Software reaches it through a 16-bit I/O window that has four word ports. One port is an index pointer. Two data ports open a control/status bank and a bus configuration bank at the index the pointer holds. A read of the fourth port restores the whole block to its power-on state. The block holds the main command register and its run-state machine. The states are stopped, initializing, init complete and running. The block also holds the 32-bit address of the setup record that the controller fetches during initialization, a descriptor-mode configuration word, and a read-only identification word pair.

The command register sends single-cycle pulses to the controller core. One pulse starts the setup-record fetch, one starts normal operation, and one asks for an immediate transmit poll. The fetch itself lies outside this block. An input strobe reports when the fetch is complete, and the block then raises its done flag. Software clears that flag by writing a one to it.

Top module: `netctl_regwin`

## Requirements
- R1: A write to byte offset 0x12 loads the index pointer with the low PTR_W bits (default 7) of the data. A read of 0x12 returns that value zero-extended, so writing 88 reads back 88 and writing 0xFFFF reads back 0x007F.
- R2: After rst_n, the command register (control index 0 via offset 0x10) reads 0x0004, the pointer reads 0, the setup-address words read 0 and all pulse outputs are low.
- R3: A read of offset 0x14 returns 0. At that clock edge it resets the block: the command register reads 0x0004, and the pointer, the setup address and the configuration word are all cleared.
- R4: Writing the command register with bit 0 set starts initialization when the block is not already initializing. init_go pulses for exactly one cycle, and the command register then reads 0x0001 (bit 0 shows initializing, and bit 2, stopped, is clear).
- R5: An init_done strobe while initializing moves the block to init complete and sets bit 8, so the command register reads 0x0100. An init_done strobe in any other state has no effect.
- R6: Writing 1 to bit 8 of the command register clears the done flag. Writing 0 to bit 8 leaves it unchanged. If init_done and the clearing write arrive in the same cycle, the flag ends up set.
- R7: Writing bit 1 from the stopped or init-complete state starts operation. run_go pulses for one cycle, and the command register then reads bit 1 set with bit 2 clear.
- R8: Writing bit 3 while running pulses tx_poll for one cycle and leaves the state unchanged. Writing bit 3 in any other state produces no pulse. Bit 3 always reads 0.
- R9: Write bits are applied in this priority order: bit 2 (stop), then bit 0 (init), then bit 1 (start). A write with bit 2 set enters the stopped state and produces no pulse. At most one of init_go, run_go and tx_poll is high in any cycle.
- R10: Control indices 1 and 2 hold the low and high halves of init_addr. Both read back what was written.
- R11: Control index 88 reads {PART_CODE[3:0], 12'h003} and index 89 reads {4'h0, PART_CODE[15:4]}. With the default 0x2621 these are 0x1003 and 0x0262. Writes to either index are ignored.
- R12: Configuration index 20, reached only through offset 0x16, reads back its written word. desc32 is high exactly when its low byte equals 2. Any control or configuration index that is not implemented reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | Window access strobe, one per cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Byte offset within the window |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, valid in the same cycle as the read strobe |
| init_done | input | 1 | Setup-record fetch finished |
| init_go | output | 1 | One-cycle pulse: start the setup-record fetch |
| run_go | output | 1 | One-cycle pulse: start operation |
| tx_poll | output | 1 | One-cycle pulse: immediate transmit poll |
| init_addr | output | 32 | Setup-record address |
| desc32 | output | 1 | 32-bit descriptor mode selected |

## Verification
The hardest case to reach is the command register's behaviour in the states that need earlier history. These are the done flag being set and then cleared in init complete, and a transmit poll requested while running. The stimulus builds each of these states through the window: it points at index 0, writes bit 0, strobes init_done at a cycle it chooses, and then writes bit 1. It then tries the same poll request in the stopped state and checks that no pulse appears. A register-populated block is then reset through a read of the reset port, to show that one side-effect read clears every bank.

// File: rtl/netctl_regwin_pkg.sv
package netctl_regwin_pkg;
   localparam int DW = 16;

   // byte offsets inside the window
   localparam logic [7:0] OFS_CSR = 8'h10;
   localparam logic [7:0] OFS_PTR = 8'h12;
   localparam logic [7:0] OFS_RST = 8'h14;
   localparam logic [7:0] OFS_BCR = 8'h16;

   // command register bit positions
   localparam int B_INIT = 0;
   localparam int B_STRT = 1;
   localparam int B_STOP = 2;
   localparam int B_TDMD = 3;
   localparam int B_IDON = 8;

   // implemented indices
   localparam int IX_CMD   = 0;
   localparam int IX_ALO   = 1;
   localparam int IX_AHI   = 2;
   localparam int IX_IDLO  = 88;
   localparam int IX_IDHI  = 89;
   localparam int IX_MODE  = 20;

   typedef enum logic [1:0] {
      ST_STOP  = 2'd0,
      ST_INIT  = 2'd1,
      ST_IDONE = 2'd2,
      ST_RUN   = 2'd3
   } run_state_e;

   typedef enum logic [2:0] {
      RS_NONE = 3'd0,
      RS_CSR  = 3'd1,
      RS_PTR  = 3'd2,
      RS_BCR  = 3'd3,
      RS_RST  = 3'd4
   } rd_src_e;
endpackage

// File: rtl/netctl_portdec.sv
module netctl_portdec
   import netctl_regwin_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int PTR_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_sel,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [PTR_W-1:0]  wr_idx,
   output logic [PTR_W-1:0]  idx,
   output logic              csr_we,
   output logic              bcr_we,
   output logic              srst,
   output rd_src_e           rd_src
);
   localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(OFS_CSR);
   localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(OFS_PTR);
   localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(OFS_RST);
   localparam logic [ADDR_W-1:0] A_BCR = ADDR_W'(OFS_BCR);

   logic hit_csr, hit_ptr, hit_rst, hit_bcr;
   logic ptr_we;

   always_comb begin
      hit_csr = io_sel && (io_addr == A_CSR);
      hit_ptr = io_sel && (io_addr == A_PTR);
      hit_rst = io_sel && (io_addr == A_RST);
      hit_bcr = io_sel && (io_addr == A_BCR);
      csr_we  = hit_csr && io_wr;
      bcr_we  = hit_bcr && io_wr;
      ptr_we  = hit_ptr && io_wr;
      srst    = hit_rst && !io_wr;
      rd_src  = RS_NONE;
      if (io_sel && !io_wr) begin
         if (hit_csr)      rd_src = RS_CSR;
         else if (hit_ptr) rd_src = RS_PTR;
         else if (hit_bcr) rd_src = RS_BCR;
         else if (hit_rst) rd_src = RS_RST;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (srst)   idx <= '0;
      else if (ptr_we) idx <= wr_idx;
   end
endmodule

// File: rtl/netctl_cmdfsm.sv
module netctl_cmdfsm
   import netctl_regwin_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       srst,
   input  logic       cmd_we,
   input  logic       w_init,
   input  logic       w_strt,
   input  logic       w_stop,
   input  logic       w_tdmd,
   input  logic       w_idon,
   input  logic       init_done,
   output run_state_e state,
   output logic       idon,
   output logic       init_go,
   output logic       run_go,
   output logic       tx_poll,
   output logic [DW-1:0] cmd_rdata
);
   logic fetch_end;

   always_comb begin
      fetch_end = (state == ST_INIT) && init_done;
      cmd_rdata = '0;
      cmd_rdata[B_INIT] = (state == ST_INIT);
      cmd_rdata[B_STRT] = (state == ST_RUN);
      cmd_rdata[B_STOP] = (state == ST_STOP);
      cmd_rdata[B_IDON] = idon;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_STOP;
         init_go <= 1'b0;
         run_go  <= 1'b0;
         tx_poll <= 1'b0;
      end else if (srst) begin
         state   <= ST_STOP;
         init_go <= 1'b0;
         run_go  <= 1'b0;
         tx_poll <= 1'b0;
      end else begin
         init_go <= 1'b0;
         run_go  <= 1'b0;
         tx_poll <= 1'b0;
         if (cmd_we && w_stop) begin
            state <= ST_STOP;
         end else if (cmd_we && w_init && state != ST_INIT) begin
            state   <= ST_INIT;
            init_go <= 1'b1;
         end else if (cmd_we && w_strt && (state == ST_STOP || state == ST_IDONE)) begin
            state  <= ST_RUN;
            run_go <= 1'b1;
         end else begin
            if (cmd_we && w_tdmd && state == ST_RUN) tx_poll <= 1'b1;
            if (fetch_end) state <= ST_IDONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                idon <= 1'b0;
      else if (srst)             idon <= 1'b0;
      else if (fetch_end)        idon <= 1'b1;
      else if (cmd_we && w_idon) idon <= 1'b0;
   end
endmodule

// File: rtl/netctl_cfgregs.sv
module netctl_cfgregs
   import netctl_regwin_pkg::*;
#(
   parameter int          PTR_W     = 7,
   parameter bit          ID_EN     = 1'b1,
   parameter logic [15:0] PART_CODE = 16'h2621,
   parameter logic [7:0]  MODE_32   = 8'd2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          srst,
   input  logic [PTR_W-1:0] idx,
   input  logic          csr_we,
   input  logic          bcr_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] csr_rdata,
   output logic [DW-1:0] bcr_rdata,
   output logic [31:0]   init_addr,
   output logic          desc32
);
   localparam logic [PTR_W-1:0] I_ALO  = PTR_W'(IX_ALO);
   localparam logic [PTR_W-1:0] I_AHI  = PTR_W'(IX_AHI);
   localparam logic [PTR_W-1:0] I_IDLO = PTR_W'(IX_IDLO);
   localparam logic [PTR_W-1:0] I_IDHI = PTR_W'(IX_IDHI);
   localparam logic [PTR_W-1:0] I_MODE = PTR_W'(IX_MODE);

   logic [DW-1:0] addr_lo, addr_hi, mode_q;
   logic [DW-1:0] id_lo, id_hi;

   generate
      if (ID_EN) begin : g_id
         assign id_lo = {PART_CODE[3:0], 12'h003};
         assign id_hi = {4'h0, PART_CODE[15:4]};
      end else begin : g_noid
         assign id_lo = '0;
         assign id_hi = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_lo <= '0;
         addr_hi <= '0;
         mode_q  <= '0;
      end else if (srst) begin
         addr_lo <= '0;
         addr_hi <= '0;
         mode_q  <= '0;
      end else begin
         if (csr_we && idx == I_ALO)  addr_lo <= wdata;
         if (csr_we && idx == I_AHI)  addr_hi <= wdata;
         if (bcr_we && idx == I_MODE) mode_q  <= wdata;
      end
   end

   always_comb begin
      unique case (idx)
         I_ALO:   csr_rdata = addr_lo;
         I_AHI:   csr_rdata = addr_hi;
         I_IDLO:  csr_rdata = id_lo;
         I_IDHI:  csr_rdata = id_hi;
         default: csr_rdata = '0;
      endcase
      bcr_rdata = (idx == I_MODE) ? mode_q : '0;
      init_addr = {addr_hi, addr_lo};
      desc32    = (mode_q[7:0] == MODE_32);
   end
endmodule

// File: rtl/netctl_regwin.sv
module netctl_regwin
   import netctl_regwin_pkg::*;
#(
   parameter int          ADDR_W    = 5,
   parameter int          PTR_W     = 7,
   parameter bit          ID_EN     = 1'b1,
   parameter logic [15:0] PART_CODE = 16'h2621
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_sel,
   input  logic              io_wr,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [15:0]       io_wdata,
   output logic [15:0]       io_rdata,
   input  logic              init_done,
   output logic              init_go,
   output logic              run_go,
   output logic              tx_poll,
   output logic [31:0]       init_addr,
   output logic              desc32
);
   generate
      if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_aw
         initial $error("ADDR_W must lie in 5..8");
      end
      if (PTR_W < 7 || PTR_W > DW) begin : g_bad_pw
         initial $error("PTR_W must lie in 7..16");
      end
   endgenerate

   logic [PTR_W-1:0] idx;
   logic             csr_we, bcr_we, srst, cmd_we;
   rd_src_e          rd_src;
   run_state_e       fsm_state;
   logic             idon_q;
   logic [DW-1:0]    cmd_rdata, csr_rdata, bcr_rdata;

   netctl_portdec #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
      .io_addr(io_addr), .wr_idx(io_wdata[PTR_W-1:0]), .idx(idx),
      .csr_we(csr_we), .bcr_we(bcr_we), .srst(srst), .rd_src(rd_src)
   );

   assign cmd_we = csr_we && (idx == PTR_W'(IX_CMD));

   netctl_cmdfsm u_fsm (
      .clk(clk), .rst_n(rst_n), .srst(srst), .cmd_we(cmd_we),
      .w_init(io_wdata[B_INIT]), .w_strt(io_wdata[B_STRT]),
      .w_stop(io_wdata[B_STOP]), .w_tdmd(io_wdata[B_TDMD]),
      .w_idon(io_wdata[B_IDON]), .init_done(init_done),
      .state(fsm_state), .idon(idon_q), .init_go(init_go),
      .run_go(run_go), .tx_poll(tx_poll), .cmd_rdata(cmd_rdata)
   );

   netctl_cfgregs #(.PTR_W(PTR_W), .ID_EN(ID_EN), .PART_CODE(PART_CODE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .srst(srst), .idx(idx),
      .csr_we(csr_we), .bcr_we(bcr_we), .wdata(io_wdata),
      .csr_rdata(csr_rdata), .bcr_rdata(bcr_rdata),
      .init_addr(init_addr), .desc32(desc32)
   );

   always_comb begin
      unique case (rd_src)
         RS_CSR:  io_rdata = (idx == PTR_W'(IX_CMD)) ? cmd_rdata : csr_rdata;
         RS_PTR:  io_rdata = DW'(idx);
         RS_BCR:  io_rdata = bcr_rdata;
         default: io_rdata = '0;
      endcase
   end
endmodule

// File: rtl/netctl_regwin_chk.sv
module netctl_regwin_chk
   import netctl_regwin_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_sel,
   input logic              io_wr,
   input logic [ADDR_W-1:0] io_addr,
   input logic [15:0]       io_rdata,
   input logic              init_done,
   input logic              init_go,
   input logic              run_go,
   input logic              tx_poll,
   input run_state_e        st,
   input logic              idon
);
   localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(OFS_RST);

   p_srst_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && !io_wr && io_addr == A_RST) |=> (st == ST_STOP && !idon));

   p_srst_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && !io_wr && io_addr == A_RST) |-> (io_rdata == 16'h0000));

   p_init_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      init_go |=> !init_go);

   p_init_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
      init_go |-> (st == ST_INIT));

   p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_INIT && init_done && !(io_sel && !io_wr && io_addr == A_RST)) |=> idon);

   p_run_enters_r7: assert property (@(posedge clk) disable iff (!rst_n)
      run_go |-> (st == ST_RUN));

   p_poll_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_poll |-> (st == ST_RUN && $past(st) == ST_RUN));

   p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({init_go, run_go, tx_poll}));
endmodule

bind netctl_regwin netctl_regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
   .io_addr(io_addr), .io_rdata(io_rdata), .init_done(init_done),
   .init_go(init_go), .run_go(run_go), .tx_poll(tx_poll),
   .st(fsm_state), .idon(idon_q)
);

// File: tb/netctl_regwin_test.sv
module netctl_regwin_test;
   localparam time TCLK = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_sel = 1'b0;
   logic        io_wr = 1'b0;
   logic [4:0]  io_addr = '0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        init_done = 1'b0;
   logic        init_go, run_go, tx_poll, desc32;
   logic [31:0] init_addr;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #(TCLK/2) clk = ~clk;

   netctl_regwin uut (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .init_done(init_done), .init_go(init_go), .run_go(run_go),
      .tx_poll(tx_poll), .init_addr(init_addr), .desc32(desc32)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // starts and ends at a falling edge
   task automatic wr(logic [4:0] a, logic [15:0] d);
      io_sel = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_sel = 1'b0; io_wr = 1'b0;
   endtask

   task automatic rd(logic [4:0] a, output logic [15:0] d);
      io_sel = 1'b1; io_wr = 1'b0; io_addr = a;
      #1 d = io_rdata;
      @(negedge clk);
      io_sel = 1'b0;
   endtask

   task automatic csr_wr(int i, logic [15:0] d);
      wr(5'h12, 16'(i));
      wr(5'h10, d);
   endtask

   task automatic csr_rd(int i, output logic [15:0] d);
      wr(5'h12, 16'(i));
      rd(5'h10, d);
   endtask

   task automatic bcr_wr(int i, logic [15:0] d);
      wr(5'h12, 16'(i));
      wr(5'h16, d);
   endtask

   task automatic bcr_rd(int i, output logic [15:0] d);
      wr(5'h12, 16'(i));
      rd(5'h16, d);
   endtask

   task automatic pulse_done();
      init_done = 1'b1;
      @(negedge clk);
      init_done = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R2 init_go", init_go, 0);
      chk("R2 run_go", run_go, 0);
      chk("R2 tx_poll", tx_poll, 0);
      rd(5'h12, d);        chk("R2 pointer", d, 0);
      csr_rd(0, d);        chk("R2 cmd", d, 16'h0004);
      csr_rd(1, d);        chk("R2 addr lo", d, 0);
      chk("R2 init_addr", init_addr, 0);
   endtask

   task automatic t_pointer();
      logic [15:0] d;
      wr(5'h12, 16'd88);   rd(5'h12, d); chk("R1 ptr 88", d, 88);
      wr(5'h12, 16'hFFFF); rd(5'h12, d); chk("R1 ptr mask", d, 16'h007F);
   endtask

   task automatic t_ident();
      logic [15:0] d;
      csr_rd(88, d); chk("R11 id lo", d, 16'h1003);
      csr_rd(89, d); chk("R11 id hi", d, 16'h0262);
      csr_wr(88, 16'hFFFF);
      csr_rd(88, d); chk("R11 id lo after write", d, 16'h1003);
      csr_wr(89, 16'h0000);
      csr_rd(89, d); chk("R11 id hi after write", d, 16'h0262);
   endtask

   task automatic t_setup_addr();
      logic [15:0] d;
      csr_wr(1, 16'hBEEF);
      csr_wr(2, 16'h1234);
      csr_rd(1, d); chk("R10 lo", d, 16'hBEEF);
      csr_rd(2, d); chk("R10 hi", d, 16'h1234);
      chk("R10 init_addr", init_addr, 32'h1234BEEF);
   endtask

   task automatic t_config();
      logic [15:0] d;
      bcr_wr(20, 16'h0102);
      chk("R12 desc32 set", desc32, 1);
      bcr_rd(20, d); chk("R12 mode readback", d, 16'h0102);
      bcr_wr(20, 16'h0003);
      chk("R12 desc32 clear", desc32, 0);
      bcr_wr(20, 16'h0002);
      csr_rd(20, d); chk("R12 control idx 20 unimplemented", d, 0);
      bcr_rd(5, d);  chk("R12 config idx 5 unimplemented", d, 0);
      csr_wr(7, 16'hAAAA);
      csr_rd(7, d);  chk("R12 control idx 7 ignores write", d, 0);
   endtask

   task automatic t_init_flow();
      logic [15:0] d;
      pulse_done();
      csr_rd(0, d); chk("R5 done ignored when stopped", d, 16'h0004);
      csr_wr(0, 16'h0001);
      chk("R4 init_go pulse", init_go, 1);
      @(negedge clk);
      chk("R4 init_go single", init_go, 0);
      csr_rd(0, d); chk("R4 cmd initializing", d, 16'h0001);
      pulse_done();
      csr_rd(0, d); chk("R5 idon set", d, 16'h0100);
      csr_wr(0, 16'h0000);
      csr_rd(0, d); chk("R6 zero leaves idon", d, 16'h0100);
      csr_wr(0, 16'h0100);
      csr_rd(0, d); chk("R6 w1c clears idon", d, 16'h0000);
      pulse_done();
      csr_rd(0, d); chk("R5 done ignored in init complete", d, 16'h0000);
   endtask

   task automatic t_init_race();
      logic [15:0] d;
      csr_wr(0, 16'h0001);
      @(negedge clk);
      wr(5'h12, 16'h0000);
      io_sel = 1'b1; io_wr = 1'b1; io_addr = 5'h10; io_wdata = 16'h0100;
      init_done = 1'b1;
      @(negedge clk);
      io_sel = 1'b0; io_wr = 1'b0; init_done = 1'b0;
      csr_rd(0, d); chk("R6 set wins over clear", d, 16'h0100);
      csr_wr(0, 16'h0100);
   endtask

   task automatic t_run();
      logic [15:0] d;
      csr_wr(0, 16'h0002);
      chk("R7 run_go pulse", run_go, 1);
      @(negedge clk);
      chk("R7 run_go single", run_go, 0);
      csr_rd(0, d); chk("R7 cmd running", d, 16'h0002);
      csr_wr(0, 16'h0008);
      chk("R8 tx_poll pulse", tx_poll, 1);
      @(negedge clk);
      chk("R8 tx_poll single", tx_poll, 0);
      csr_rd(0, d); chk("R8 state kept, bit 3 reads 0", d, 16'h0002);
   endtask

   task automatic t_stop();
      logic [15:0] d;
      csr_wr(0, 16'h0004);
      chk("R9 stop no run pulse", run_go, 0);
      csr_rd(0, d); chk("R9 stopped", d, 16'h0004);
      csr_wr(0, 16'h0008);
      chk("R8 no poll when stopped", tx_poll, 0);
      csr_wr(0, 16'h0005);
      chk("R9 stop beats init", init_go, 0);
      csr_rd(0, d); chk("R9 stop beats init state", d, 16'h0004);
      csr_wr(0, 16'h0003);
      chk("R9 init beats start go", init_go, 1);
      chk("R9 init beats start run", run_go, 0);
      csr_rd(0, d); chk("R9 init state", d, 16'h0001);
   endtask

   task automatic t_softreset();
      logic [15:0] d;
      csr_wr(1, 16'h5555);
      bcr_wr(20, 16'h0002);
      wr(5'h12, 16'd42);
      rd(5'h14, d); chk("R3 reset port reads 0", d, 0);
      chk("R3 init_addr cleared", init_addr, 0);
      chk("R3 desc32 cleared", desc32, 0);
      rd(5'h12, d); chk("R3 pointer cleared", d, 0);
      rd(5'h10, d); chk("R3 cmd stopped", d, 16'h0004);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pointer();
      t_ident();
      t_setup_addr();
      t_config();
      t_init_flow();
      t_init_race();
      t_run();
      t_stop();
      t_softreset();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule